// File: doc/BRIEF.md
# USB Transmit Line Encoder

This block is the transmit half of a soft USB 2.0 physical layer. A link controller hands it bytes over a valid/ready byte stream. The block starts each packet with the SYNC pattern. It sends each byte least significant bit first, adds a stuff bit after six ones in a row, NRZI-encodes the result and ends the packet with an end-of-packet marker. On every byte clock it produces one line symbol for each of eight serializer slots, and it drives a per-slot output enable for the line drivers.

Back-pressure works like this. A byte moves only on a clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` depends only on internal state, never on `tx_valid_i` or `tx_data_i`. It stays low while the block is idle and during the cycle in which SYNC is loaded. It also drops whenever inserted stuff bits leave more than one byte of bits waiting. The controller must keep `tx_valid_i` high for the whole packet. Dropping it marks the last byte, and the block then drains its queue and appends the end-of-packet marker. A new packet should start only once the line has returned to idle.

Top module: `usb_tx_encoder`

## Requirements
- R1: After reset every slot's output enable is 0 and `tx_ready_o` is 0. The line shows idle J: at high or full speed J means dp=1 and dm=0 in every slot.
- R2: A byte is consumed only on an edge where `tx_valid_i` and `tx_ready_o` are both high. Every byte offered in a packet is consumed exactly once and none is lost.
- R3: Each packet's line output begins with the eight-symbol SYNC sequence K J K J K J K K.
- R4: Data bits are sent least significant bit first and NRZI-encoded. A 0 changes the line between J and K, a 1 keeps it, and the starting level is J.
- R5: Outside raw mode, a 0 is inserted after six consecutive 1 bits, and the stuff bit also toggles the line. This includes six ones that end the last byte, in which case the stuff bit comes before the end-of-packet marker.
- R6: After the last bit, two SE0 bit times (dp=0, dm=0) and one J bit time follow. After that every output enable is 0 and the line stays at J.
- R7: With speed select 2'b00 (high speed) one bit time occupies one slot, so eight bit times leave per byte clock. Slot 0 is the earliest in time.
- R8: With speed select 2'b01 (full speed) one bit time fills 40 slots (5 byte clocks). With 2'b10 (low speed) it fills 320 slots (40 byte clocks), and J is dp=0, dm=1.
- R9: With mode select 2'b01 every output enable stays 0, while the handshake still consumes the whole packet.
- R10: With mode select 2'b10 stuffing and NRZI are bypassed. Each bit drives the line directly, 1 as J and 0 as K, and SYNC and end-of-packet framing are still added.
- R11: When stuff bits back up the queue, `tx_ready_o` goes low mid-packet, and the queue never holds more than two bytes of bits.
- R12: During a packet the output enable is high for one unbroken run of slots, from the first SYNC symbol through the final J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Asynchronous reset, active high |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte offered; a fall marks packet end |
| tx_ready_o | output | 1 | Block takes the byte on this edge if valid |
| opmode_i | input | 2 | 00 normal, 01 drivers off, 10 raw (no stuffing, no NRZI), 11 treated as normal |
| speed_i | input | 2 | 00 high speed, 01 full speed, 10 low speed, 11 treated as high speed |
| line_dp_o | output | 8 | Data+ level for each serializer slot, bit 0 first |
| line_dm_o | output | 8 | Data- level for each serializer slot, bit 0 first |
| line_oe_o | output | 8 | Driver enable for each serializer slot |

## Verification
The hardest state to reach is the ready throttle. The queue only fills past one byte after a long run of all-ones bytes, once enough stuff bits have piled up to cost the link a full byte slot. The bench sends twelve 0xFF bytes back to back, counts the cycles in which ready is low while data is offered, and checks the encoded line slot by slot. Another corner is a stuff bit that must go out just before the end-of-packet marker. A final byte of 0xFC reaches it, because its six trailing ones end the data.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PKT  = 2'd1,
    PH_SE0B = 2'd2,
    PH_JEND = 2'd3
  } tx_phase_e;

  // line symbol codes carried between lane engine and line map
  localparam logic [1:0] SYM_J   = 2'd0;
  localparam logic [1:0] SYM_K   = 2'd1;
  localparam logic [1:0] SYM_SE0 = 2'd2;

  localparam logic [1:0] OPM_NODRIVE = 2'b01;
  localparam logic [1:0] OPM_RAW     = 2'b10;
  localparam logic [1:0] SPD_FS      = 2'b01;
  localparam logic [1:0] SPD_LS      = 2'b10;
endpackage

// File: rtl/usb_tx_rate.sv
module usb_tx_rate #(
  parameter int FS_DIV = 5,
  parameter int LS_DIV = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart_i,
  input  logic       ls_i,
  output logic       tick_o
);
  localparam int CNT_W = $clog2(LS_DIV + 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      cnt_q <= '0;
    else if (restart_i)
      cnt_q <= '0;
    else if (cnt_q == '0)
      cnt_q <= ls_i ? CNT_W'(LS_DIV - 1) : CNT_W'(FS_DIV - 1);
    else
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/usb_tx_lanes.sv
module usb_tx_lanes
  import usb_tx_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int QW    = 16,
  parameter int CW    = 5
) (
  input  tx_phase_e              phase_i,
  input  logic [QW-1:0]          q_i,
  input  logic [CW-1:0]          qn_i,
  input  logic [2:0]             run_i,
  input  logic                   lvl_i,
  input  logic                   ended_i,
  input  logic                   raw_i,
  input  logic                   hs_i,
  input  logic                   tick_i,
  output tx_phase_e              phase_o,
  output logic [QW-1:0]          q_o,
  output logic [CW-1:0]          qn_o,
  output logic [2:0]             run_o,
  output logic                   lvl_o,
  output logic [SLOTS-1:0][1:0]  sym_o,
  output logic [SLOTS-1:0]       oe_o
);
  always_comb begin
    tx_phase_e      ph;
    logic [QW-1:0]  q;
    logic [CW-1:0]  qn;
    logic [2:0]     run;
    logic           lvl;
    logic           b;
    ph  = phase_i;
    q   = q_i;
    qn  = qn_i;
    run = run_i;
    lvl = lvl_i;
    b   = 1'b0;
    sym_o = '0;
    oe_o  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (hs_i || (tick_i && k == 0)) begin
        case (ph)
          PH_PKT: begin
            oe_o[k] = 1'b1;
            if (!raw_i && run == 3'd6) begin
              lvl      = ~lvl;
              run      = '0;
              sym_o[k] = lvl ? SYM_J : SYM_K;
            end else if (qn != '0) begin
              b   = q[0];
              q   = {1'b0, q[QW-1:1]};
              qn  = qn - CW'(1);
              if (raw_i)  lvl = b;
              else if (!b) lvl = ~lvl;
              run      = (b && !raw_i) ? run + 3'd1 : 3'd0;
              sym_o[k] = lvl ? SYM_J : SYM_K;
            end else if (ended_i) begin
              ph       = PH_SE0B;
              sym_o[k] = SYM_SE0;
            end else begin
              sym_o[k] = lvl ? SYM_J : SYM_K;
            end
          end
          PH_SE0B: begin
            oe_o[k]  = 1'b1;
            sym_o[k] = SYM_SE0;
            ph       = PH_JEND;
          end
          PH_JEND: begin
            oe_o[k]  = 1'b1;
            sym_o[k] = SYM_J;
            lvl      = 1'b1;
            ph       = PH_IDLE;
          end
          default: sym_o[k] = SYM_J;
        endcase
      end
    end
    phase_o = ph;
    q_o     = q;
    qn_o    = qn;
    run_o   = run;
    lvl_o   = lvl;
  end
endmodule

// File: rtl/usb_tx_linemap.sv
module usb_tx_linemap
  import usb_tx_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic [SLOTS-1:0][1:0] sym_i,
  input  logic                  ls_i,
  output logic [SLOTS-1:0]      dp_o,
  output logic [SLOTS-1:0]      dm_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      case (sym_i[k])
        SYM_J:   {dp_o[k], dm_o[k]} = ls_i ? 2'b01 : 2'b10;
        SYM_K:   {dp_o[k], dm_o[k]} = ls_i ? 2'b10 : 2'b01;
        default: {dp_o[k], dm_o[k]} = 2'b00;
      endcase
    end
  end
endmodule

// File: rtl/usb_tx_encoder.sv
module usb_tx_encoder
  import usb_tx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int SLOTS  = 8,
  parameter int FS_DIV = 5,
  parameter int LS_DIV = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [1:0]       opmode_i,
  input  logic [1:0]       speed_i,
  output logic [SLOTS-1:0] line_dp_o,
  output logic [SLOTS-1:0] line_dm_o,
  output logic [SLOTS-1:0] line_oe_o
);
  localparam int QW = 2 * DW;
  localparam int CW = $clog2(QW + 1);
  localparam logic [DW-1:0] SYNC_BYTE = DW'(1) << (DW - 1);

  tx_phase_e            phase_q, l_phase;
  logic [QW-1:0]        q_q, l_q, q_push;
  logic [CW-1:0]        qn_q, l_qn;
  logic [2:0]           run_q, l_run;
  logic                 lvl_q, l_lvl;
  logic                 ended_q;
  logic [SLOTS-1:0][1:0] sym_q, l_sym;
  logic [SLOTS-1:0]     oe_q, l_oe, drv_gate;
  logic                 hs, ls, raw, tick, start, accept;

  assign hs       = (speed_i != SPD_FS) && (speed_i != SPD_LS);
  assign ls       = (speed_i == SPD_LS);
  assign raw      = (opmode_i == OPM_RAW);
  assign drv_gate = {SLOTS{opmode_i != OPM_NODRIVE}};
  assign start    = (phase_q == PH_IDLE) && tx_valid_i;

  usb_tx_rate #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) u_rate (
    .clk(clk), .rst(rst), .restart_i(start), .ls_i(ls), .tick_o(tick)
  );

  usb_tx_lanes #(.SLOTS(SLOTS), .QW(QW), .CW(CW)) u_lanes (
    .phase_i(phase_q), .q_i(q_q), .qn_i(qn_q), .run_i(run_q), .lvl_i(lvl_q),
    .ended_i(ended_q), .raw_i(raw), .hs_i(hs), .tick_i(tick),
    .phase_o(l_phase), .q_o(l_q), .qn_o(l_qn), .run_o(l_run), .lvl_o(l_lvl),
    .sym_o(l_sym), .oe_o(l_oe)
  );

  usb_tx_linemap #(.SLOTS(SLOTS)) u_map (
    .sym_i(sym_q), .ls_i(ls), .dp_o(line_dp_o), .dm_o(line_dm_o)
  );

  assign tx_ready_o = (phase_q == PH_PKT) && !ended_q && (l_qn <= CW'(DW));
  assign accept     = tx_ready_o && tx_valid_i;
  assign q_push     = l_q | (QW'(tx_data_i) << l_qn);
  assign line_oe_o  = oe_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      q_q     <= '0;
      qn_q    <= '0;
      run_q   <= '0;
      lvl_q   <= 1'b1;
      ended_q <= 1'b0;
      sym_q   <= '0;
      oe_q    <= '0;
    end else if (start) begin
      phase_q <= PH_PKT;
      q_q     <= QW'(SYNC_BYTE);
      qn_q    <= CW'(DW);
      run_q   <= '0;
      lvl_q   <= 1'b1;
      ended_q <= 1'b0;
      sym_q   <= '0;
      oe_q    <= '0;
    end else begin
      phase_q <= l_phase;
      q_q     <= accept ? q_push : l_q;
      qn_q    <= accept ? l_qn + CW'(DW) : l_qn;
      run_q   <= l_run;
      lvl_q   <= l_lvl;
      ended_q <= (phase_q == PH_PKT) && (ended_q || !tx_valid_i);
      if (hs) begin
        sym_q <= l_sym;
        oe_q  <= l_oe & drv_gate;
      end else if (tick) begin
        sym_q <= {SLOTS{l_sym[0]}};
        oe_q  <= {SLOTS{l_oe[0]}} & drv_gate;
      end
    end
  end
endmodule

// File: rtl/usb_tx_checker.sv
module usb_tx_checker
  import usb_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SLOTS = 8,
  parameter int QW    = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid_i,
  input logic [1:0]       opmode_i,
  input tx_phase_e        phase_q,
  input logic [QW-1:0]    q_q,
  input logic [CW-1:0]    qn_q,
  input logic [2:0]       run_q,
  input logic             ended_q,
  input logic [SLOTS-1:0] line_oe_o
);
  localparam logic [DW-1:0] SYNC_BYTE = DW'(1) << (DW - 1);

  p_sync_load_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && tx_valid_i) |=>
      (phase_q == PH_PKT && qn_q == CW'(DW) && q_q[DW-1:0] == SYNC_BYTE));

  p_no_underrun_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PKT && !ended_q) |-> (qn_q >= CW'(DW)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    qn_q <= CW'(QW));

  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_q <= 3'd6);

  p_nodrive_r9: assert property (@(posedge clk) disable iff (rst)
    (opmode_i == OPM_NODRIVE) |=> (line_oe_o == '0));
endmodule

bind usb_tx_encoder usb_tx_checker #(
  .DW(DW), .SLOTS(SLOTS), .QW(QW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .tx_valid_i(tx_valid_i), .opmode_i(opmode_i),
  .phase_q(phase_q), .q_q(q_q), .qn_q(qn_q), .run_q(run_q),
  .ended_q(ended_q), .line_oe_o(line_oe_o)
);

// File: tb/sim_usb_tx_encoder.sv
module sim_usb_tx_encoder;
  localparam int SJ = 0, SK = 1, SSE0 = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [1:0] opmode = 2'b00;
  logic [1:0] speed = 2'b00;
  logic [7:0] dp, dm, oe;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] pkt [0:15];
  int exp_sym [0:511];
  int exp_n = 0, rep = 1;
  bit cap_en = 0;
  int cap_idx, mism, sync_bad, gap, oe_state, hs_cnt, low_cnt;

  usb_tx_encoder u0 (
    .clk(clk), .rst(rst), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .opmode_i(opmode), .speed_i(speed),
    .line_dp_o(dp), .line_dm_o(dm), .line_oe_o(oe)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int decode(logic p, logic m);
    logic ls;
    ls = (speed == 2'b10);
    if (!p && !m) return SSE0;
    if ({p, m} == (ls ? 2'b01 : 2'b10)) return SJ;
    return SK;
  endfunction

  // slot capture and handshake monitor, sampled mid-cycle
  always begin
    @(negedge clk);
    #1;
    if (cap_en) begin
      if (tx_valid && tx_ready) hs_cnt++;
      if (tx_valid && !tx_ready && hs_cnt > 0) low_cnt++;
      for (int k = 0; k < 8; k++) begin
        if (oe[k]) begin
          int s, bi;
          if (oe_state == 2) gap++;
          oe_state = 1;
          s = decode(dp[k], dm[k]);
          bi = cap_idx / rep;
          if (bi >= exp_n || s != exp_sym[bi]) mism++;
          if (bi < 8 && s != ((bi == 7 || bi % 2 == 0) ? SK : SJ)) sync_bad++;
          cap_idx++;
        end else if (oe_state == 1) begin
          oe_state = 2;
        end
      end
    end
  end

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic build_exp(int n, bit raw);
    int lvl, run;
    lvl = SJ; run = 0; exp_n = 0;
    for (int i = 0; i <= n; i++) begin
      logic [7:0] by;
      by = (i == 0) ? 8'h80 : pkt[i-1];
      for (int j = 0; j < 8; j++) begin
        int bv;
        bv = (by >> j) & 1;
        if (raw) begin
          exp_sym[exp_n++] = bv ? SJ : SK;
        end else begin
          if (bv == 0) lvl = (lvl == SJ) ? SK : SJ;
          exp_sym[exp_n++] = lvl;
          run = bv ? run + 1 : 0;
          if (run == 6) begin
            lvl = (lvl == SJ) ? SK : SJ;
            exp_sym[exp_n++] = lvl;
            run = 0;
          end
        end
      end
    end
    exp_sym[exp_n++] = SSE0;
    exp_sym[exp_n++] = SSE0;
    exp_sym[exp_n++] = SJ;
  endtask

  task automatic run_pkt(string tag, logic [1:0] spd, logic [1:0] opm, int n);
    int i;
    bit r;
    @(negedge clk);
    speed = spd; opmode = opm;
    rep = (spd == 2'b01) ? 40 : (spd == 2'b10) ? 320 : 1;
    build_exp(n, opm == 2'b10);
    cap_idx = 0; mism = 0; sync_bad = 0; gap = 0; oe_state = 0;
    hs_cnt = 0; low_cnt = 0;
    cap_en = 1;
    tx_valid = 1'b1; tx_data = pkt[0]; i = 0;
    while (i < n) begin
      r = tx_ready;
      @(negedge clk);
      if (r) begin
        i++;
        if (i < n) tx_data = pkt[i];
        else tx_valid = 1'b0;
      end
    end
    repeat ((30 * rep) / 8 + 12) @(negedge clk);
    cap_en = 0;
    check({tag, " R2 bytes consumed"}, hs_cnt, n);
    if (opm == 2'b01) begin
      check({tag, " R9 enabled slots"}, cap_idx, 0);
    end else begin
      check({tag, " R7/R8 slot count"}, cap_idx, exp_n * rep);
      check({tag, " R4 R5 R6 symbol mismatches"}, mism, 0);
      check({tag, " R12 enable gaps"}, gap, 0);
      if (opm != 2'b10) check({tag, " R3 sync mismatches"}, sync_bad, 0);
    end
    check({tag, " R6 idle enable"}, int'(oe), 0);
    check({tag, " R6 idle line J"}, decode(dp[0], dm[0]), SJ);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 enable after reset", int'(oe), 0);
    check("R1 ready after reset", int'(tx_ready), 0);
    check("R1 dp idle", int'(dp), 8'hFF);
    check("R1 dm idle", int'(dm), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    run_pkt("HS pattern R4", 2'b00, 2'b00, 2);

    for (int k = 0; k < 12; k++) pkt[k] = 8'hFF;
    run_pkt("HS ones R5", 2'b00, 2'b00, 12);
    tests++;
    if (low_cnt == 0) begin
      fails++;
      $display("FAIL R11 ready throttle: actual %0d expected >0", low_cnt);
    end

    pkt[0] = 8'h12; pkt[1] = 8'hFC;
    run_pkt("HS trailing stuff R5", 2'b00, 2'b00, 2);

    for (int k = 0; k < 5; k++) pkt[k] = 8'h00;
    run_pkt("HS zeros R4", 2'b00, 2'b00, 5);

    for (int k = 0; k < 16; k++) pkt[k] = 8'(k * 17 + 3);
    run_pkt("HS ramp R7", 2'b00, 2'b00, 16);

    pkt[0] = 8'hC3; pkt[1] = 8'h7E;
    run_pkt("FS R8", 2'b01, 2'b00, 2);

    pkt[0] = 8'h5A;
    run_pkt("LS R8", 2'b10, 2'b00, 1);

    pkt[0] = 8'hFF; pkt[1] = 8'h00; pkt[2] = 8'h81;
    run_pkt("HS raw R10", 2'b00, 2'b10, 3);

    pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
    run_pkt("HS nodrive R9", 2'b00, 2'b01, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule